// File: doc/BRIEF.md
# Serial Flash Pin-Role and Hold Controller

This block sits at the pin front end of a serial NOR flash slave that can run with one, two or four data lanes. Three package pins do two jobs each. The pause pin can also carry data lane 3. The protection pin can also carry data lane 2. The supply-boost pin can also carry a data lane. For each of these pins, the block decides from the active lane mode, the current command class, two hold-enable configuration bits, a boost-disable configuration bit and a double-rate flag whether the pin is a control input or a data lane.

When the pause pin is a control input, the block turns it into a registered hold signal. The hold signal freezes the serial shift engine and puts the DQ1 output lane into high impedance while the device stays selected. Hold changes are taken only while the serial clock is low, so a pause never splits a bit. The block also reports whether write protection is asserted. After the last data bit of a four-lane program or erase, it opens a timed window in which the boost-supply flag may arrive. It then gives a one-cycle verdict: accelerated or standard speed.

Top module: `sfpin_ctrl`

## Requirements
- R1: While `cs_n` is high at a `clk` edge, `hold_pause` is 0 after that edge, whatever the pause pin does.
- R2: While hold is usable, `hold_pause` takes the inverse of `hold_n_pin` at each `clk` edge where `sclk` is 0. At edges where `sclk` is 1 it keeps its value.
- R3: When `proto[1]` is 1 (four-lane protocol) or `quad_cmd` is 1, `dq3_is_data` and `dq2_is_data` are 1, and `hold_pause` is 0 after the next edge.
- R4: When either `nv_hold_en` or `ev_hold_en` is 0, hold is unusable and `hold_pause` is 0 after the next edge.
- R5: If `dtr_seen` is 1 at an edge while `cs_n` is low, hold stays unusable from that edge until an edge with `cs_n` high, even if `dtr_seen` returns to 0.
- R6: With `proto` 2'b00 or 2'b01 and `quad_cmd` 0, the protection pin is a control input and `wp_active` equals the inverse of `wp_n_pin`. Otherwise `wp_active` is 0.
- R7: `vpp_is_data` is 1 only when `vpp_dis_cfg` is 0 and the operation is four-lane (`proto[1]` or `quad_cmd` is 1).
- R8: An edge that samples `prog_last` high with `vpp_is_data` 1 opens a window of WIN edges. If `acc_volt_ok` is sampled high on any of those edges, `acc_go` pulses for one cycle after the first such edge. If it is not, `std_go` pulses for one cycle after the WIN-th edge. `acc_wait` is 1 while the window is open.
- R9: An edge that samples `prog_last` high with `vpp_is_data` 0 and no window open gives a `std_go` pulse after that edge, and no window opens.
- R10: During reset, `hold_pause`, `acc_wait`, `acc_go` and `std_go` are 0. `acc_go` and `std_go` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock level, sampled by `clk` |
| hold_n_pin | input | 1 | Pause pin / data lane 3, active low as pause |
| wp_n_pin | input | 1 | Protection pin / data lane 2, active low |
| proto | input | 2 | Lane mode: 00 single, 01 dual, 1x quad |
| quad_cmd | input | 1 | Current command uses four lanes |
| dtr_seen | input | 1 | Double-rate operation recognised |
| nv_hold_en | input | 1 | Nonvolatile hold enable, 0 disables |
| ev_hold_en | input | 1 | Volatile hold enable, 0 disables |
| vpp_dis_cfg | input | 1 | Boost-pin disable, 1 (reset default) disables |
| prog_last | input | 1 | Last data bit of a four-lane program/erase shifted in |
| acc_volt_ok | input | 1 | Boost supply present |
| dq3_is_data | output | 1 | Pause pin is a data lane |
| dq2_is_data | output | 1 | Protection pin is a data lane |
| vpp_is_data | output | 1 | Boost pin is a data lane |
| wp_active | output | 1 | Write protection asserted |
| hold_pause | output | 1 | Freeze shift engine, DQ1 output in high impedance |
| acc_wait | output | 1 | Boost window open |
| acc_go | output | 1 | One-cycle verdict: accelerated |
| std_go | output | 1 | One-cycle verdict: standard speed |

## Verification
Two things can happen in the same edge: the boost flag can arrive on exactly the window's final edge, where the timeout would also fire, and a hold request can arrive in the edge where a double-rate flag or a deselect removes hold. The bench sweeps the flag arrival across every window position and one position past the end. It also drives pause-low together with `dtr_seen` or `cs_n` high. A behavioural model compares the outputs every cycle and expects the accelerated verdict to win on the last edge, and disable to win over entry.

// File: rtl/sfpin_pkg.sv
package sfpin_pkg;

  typedef enum logic [1:0] {
    LANES_ONE  = 2'b00,
    LANES_TWO  = 2'b01,
    LANES_FOUR = 2'b10
  } lane_mode_e;

  typedef enum logic {
    ACC_IDLE = 1'b0,
    ACC_WAIT = 1'b1
  } acc_state_e;

  // Four-lane operation: any mode with bit 1 set, or a four-lane command.
  function automatic logic wide_lanes(input logic [1:0] mode, input logic qcmd);
    return mode[1] | qcmd;
  endfunction

  // Hold may act only when selected, the pause pin is not a data lane,
  // both enable bits permit it and no double-rate operation is seen.
  function automatic logic hold_usable(input logic selected,
                                       input logic pin_is_lane,
                                       input logic nv_en,
                                       input logic ev_en,
                                       input logic dtr_now,
                                       input logic dtr_latched);
    return selected & ~pin_is_lane & nv_en & ev_en & ~dtr_now & ~dtr_latched;
  endfunction

  // Counter width for a window of n cycles.
  function automatic int win_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sfpin_role.sv
module sfpin_role
  import sfpin_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] proto,
  input  logic       quad_cmd,
  input  logic       vpp_dis_cfg,
  input  logic       wp_n_pin,
  output logic       dq3_is_data,
  output logic       dq2_is_data,
  output logic       vpp_is_data,
  output logic       wp_active
);

  logic four_lane;

  assign four_lane   = wide_lanes(proto, quad_cmd);
  assign dq3_is_data = four_lane;
  assign dq2_is_data = four_lane;
  assign vpp_is_data = four_lane & ~vpp_dis_cfg;
  assign wp_active   = ~dq2_is_data & ~wp_n_pin;

  // R6: protection never asserted while the pin carries data
  a_r6_wp_ctrl_only: assert property (@(posedge clk) disable iff (!rst_n)
    wp_active |-> (proto[1] == 1'b0 && quad_cmd == 1'b0));

  // R7: boost pin is a lane only when its disable bit is clear
  a_r7_vpp_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_is_data |-> (!vpp_dis_cfg && dq2_is_data));

endmodule

// File: rtl/sfpin_hold.sv
module sfpin_hold
  import sfpin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic hold_n_pin,
  input  logic dq3_is_data,
  input  logic nv_hold_en,
  input  logic ev_hold_en,
  input  logic dtr_seen,
  output logic hold_pause
);

  logic dtr_lock_q;
  logic hold_q;
  logic hold_ok;
  logic selected;

  assign selected = ~cs_n;
  assign hold_ok  = hold_usable(selected, dq3_is_data, nv_hold_en,
                                ev_hold_en, dtr_seen, dtr_lock_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dtr_lock_q <= 1'b0;
      hold_q     <= 1'b0;
    end else begin
      dtr_lock_q <= selected & (dtr_lock_q | dtr_seen);
      if (!hold_ok)
        hold_q <= 1'b0;
      else if (!sclk)
        hold_q <= ~hold_n_pin;
    end
  end

  assign hold_pause = hold_q;

  // R1: deselect always ends a pause
  a_r1_no_hold_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !hold_pause);

  // R2: hold state never changes mid-bit
  a_r2_stable_sclk_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && hold_ok) |=> $stable(hold_pause));

  // R3: four-lane pin cannot pause
  a_r3_lane_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dq3_is_data |=> !hold_pause);

  // R4: either enable bit at 0 blocks hold
  a_r4_cfg_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (!nv_hold_en || !ev_hold_en) |=> !hold_pause);

  // R5: a double-rate operation keeps hold off while selected
  a_r5_dtr_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (dtr_seen && !cs_n) |=> (!cs_n |=> !hold_pause));

endmodule

// File: rtl/sfpin_accel.sv
module sfpin_accel
  import sfpin_pkg::*;
#(
  parameter int WIN = 20_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_last,
  input  logic vpp_is_data,
  input  logic acc_volt_ok,
  output logic acc_wait,
  output logic acc_go,
  output logic std_go
);

  localparam int CW = win_bits(WIN);
  localparam logic [CW-1:0] LAST_CNT = CW'(WIN - 1);

  acc_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          acc_q;
  logic          std_q;
  logic          window_end;

  assign window_end = (cnt_q == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ACC_IDLE;
      cnt_q   <= '0;
      acc_q   <= 1'b0;
      std_q   <= 1'b0;
    end else begin
      acc_q <= 1'b0;
      std_q <= 1'b0;
      unique case (state_q)
        ACC_IDLE: begin
          cnt_q <= '0;
          if (prog_last) begin
            if (vpp_is_data) state_q <= ACC_WAIT;
            else             std_q   <= 1'b1;
          end
        end
        ACC_WAIT: begin
          if (acc_volt_ok) begin
            acc_q   <= 1'b1;
            state_q <= ACC_IDLE;
          end else if (window_end) begin
            std_q   <= 1'b1;
            state_q <= ACC_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ACC_IDLE;
      endcase
    end
  end

  assign acc_wait = (state_q == ACC_WAIT);
  assign acc_go   = acc_q;
  assign std_go   = std_q;

  // R10: verdicts are exclusive
  a_r10_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({acc_go, std_go}) <= 1);

  // R8: accelerated verdict only ends an open window
  a_r8_acc_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    acc_go |-> $past(acc_wait));

  // R8: an open window with the flag present closes with acceleration
  a_r8_flag_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wait && acc_volt_ok) |=> (acc_go && !acc_wait));

  // R9: a direct standard verdict never opens a window
  a_r9_no_window: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_wait && prog_last && !vpp_is_data) |=> (std_go && !acc_wait));

endmodule

// File: rtl/sfpin_ctrl.sv
module sfpin_ctrl
  import sfpin_pkg::*;
#(
  parameter int WIN = 20_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       hold_n_pin,
  input  logic       wp_n_pin,
  input  logic [1:0] proto,
  input  logic       quad_cmd,
  input  logic       dtr_seen,
  input  logic       nv_hold_en,
  input  logic       ev_hold_en,
  input  logic       vpp_dis_cfg,
  input  logic       prog_last,
  input  logic       acc_volt_ok,
  output logic       dq3_is_data,
  output logic       dq2_is_data,
  output logic       vpp_is_data,
  output logic       wp_active,
  output logic       hold_pause,
  output logic       acc_wait,
  output logic       acc_go,
  output logic       std_go
);

  sfpin_role u_role (
    .clk         (clk),
    .rst_n       (rst_n),
    .proto       (proto),
    .quad_cmd    (quad_cmd),
    .vpp_dis_cfg (vpp_dis_cfg),
    .wp_n_pin    (wp_n_pin),
    .dq3_is_data (dq3_is_data),
    .dq2_is_data (dq2_is_data),
    .vpp_is_data (vpp_is_data),
    .wp_active   (wp_active)
  );

  sfpin_hold u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .sclk        (sclk),
    .hold_n_pin  (hold_n_pin),
    .dq3_is_data (dq3_is_data),
    .nv_hold_en  (nv_hold_en),
    .ev_hold_en  (ev_hold_en),
    .dtr_seen    (dtr_seen),
    .hold_pause  (hold_pause)
  );

  sfpin_accel #(.WIN(WIN)) u_accel (
    .clk         (clk),
    .rst_n       (rst_n),
    .prog_last   (prog_last),
    .vpp_is_data (vpp_is_data),
    .acc_volt_ok (acc_volt_ok),
    .acc_wait    (acc_wait),
    .acc_go      (acc_go),
    .std_go      (std_go)
  );

  // R3: a paused engine implies the pause pin was a control input one edge ago
  a_r3_pause_needs_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_pause) |-> !$past(dq3_is_data));

endmodule

// File: tb/sfpin_ctrl_tb_top.sv
module sfpin_ctrl_tb_top;

  localparam int WIN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, hold_n_pin = 1'b1, wp_n_pin = 1'b1;
  logic [1:0] proto = 2'b00;
  logic quad_cmd = 1'b0, dtr_seen = 1'b0, nv_hold_en = 1'b1, ev_hold_en = 1'b1;
  logic vpp_dis_cfg = 1'b1, prog_last = 1'b0, acc_volt_ok = 1'b0;
  logic dq3_is_data, dq2_is_data, vpp_is_data, wp_active;
  logic hold_pause, acc_wait, acc_go, std_go;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sfpin_ctrl #(.WIN(WIN)) dut_i (.*);

  // Behavioural reference state
  bit m_hold = 0, m_dtr = 0, m_acc = 0, m_std = 0, m_waiting = 0;
  int m_elapsed = 0;

  function automatic bit m_four();
    return (proto == 2'b10) || (proto == 2'b11) || quad_cmd;
  endfunction

  always @(posedge clk) begin
    bit allowed;
    if (!rst_n) begin
      m_hold = 0; m_dtr = 0; m_acc = 0; m_std = 0; m_waiting = 0; m_elapsed = 0;
    end else begin
      allowed = !cs_n && !m_four() && nv_hold_en && ev_hold_en && !dtr_seen && !m_dtr;
      if (!allowed) m_hold = 0;
      else if (sclk == 1'b0) m_hold = !hold_n_pin;
      m_dtr = !cs_n && (m_dtr || dtr_seen);
      m_acc = 0; m_std = 0;
      if (m_waiting) begin
        m_elapsed++;
        if (acc_volt_ok) begin m_acc = 1; m_waiting = 0; end
        else if (m_elapsed == WIN) begin m_std = 1; m_waiting = 0; end
      end else if (prog_last) begin
        if (m_four() && !vpp_dis_cfg) begin m_waiting = 1; m_elapsed = 0; end
        else m_std = 1;
      end
    end
  end

  task automatic chk(input string tag, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic compare();
    chk("R3 dq3_is_data", dq3_is_data, m_four());
    chk("R3 dq2_is_data", dq2_is_data, m_four());
    chk("R7 vpp_is_data", vpp_is_data, m_four() && !vpp_dis_cfg);
    chk("R6 wp_active", wp_active, !m_four() && !wp_n_pin);
    chk("R1/R2/R4/R5 hold_pause", hold_pause, m_hold);
    chk("R8 acc_wait", acc_wait, m_waiting);
    chk("R8 acc_go", acc_go, m_acc);
    chk("R9 std_go", std_go, m_std);
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #0.5;
      compare();
    end
  endtask

  initial begin
    // R10: reset state
    step(3);
    chk("R10 reset hold", hold_pause, 1'b0);
    chk("R10 reset verdict", acc_go | std_go | acc_wait, 1'b0);
    rst_n = 1'b1;
    step(1);

    // R3 R4 R5 exhaustive sweep of lane mode, command class, enables, DTR
    for (int p = 0; p < 4; p++)
      for (int q = 0; q < 2; q++)
        for (int nv = 0; nv < 2; nv++)
          for (int ev = 0; ev < 2; ev++)
            for (int d = 0; d < 2; d++) begin
              cs_n = 1; hold_n_pin = 1; dtr_seen = 0;
              step(1);
              proto = 2'(p); quad_cmd = 1'(q);
              nv_hold_en = 1'(nv); ev_hold_en = 1'(ev);
              cs_n = 0; dtr_seen = 1'(d);
              step(1);
              dtr_seen = 0; hold_n_pin = 0;   // R5: lock persists after flag drops
              step(2);
              hold_n_pin = 1;
              step(1);
            end

    // R1: pause while deselected, and deselect during a pause
    proto = 2'b00; quad_cmd = 0; nv_hold_en = 1; ev_hold_en = 1;
    cs_n = 1; hold_n_pin = 0; step(2);
    cs_n = 0; step(2);
    cs_n = 1; step(2);

    // R2: pause edges while sclk high are held off until sclk falls
    cs_n = 0; hold_n_pin = 1; step(1);
    sclk = 1; hold_n_pin = 0; step(2);
    sclk = 0; step(1);
    sclk = 1; hold_n_pin = 1; step(2);
    sclk = 0; step(1);
    // R5: DTR and pause entry in the same edge
    hold_n_pin = 0; dtr_seen = 1; step(1);
    dtr_seen = 0; step(2);
    cs_n = 1; step(1);
    cs_n = 0; step(2);
    hold_n_pin = 1; cs_n = 1; step(1);

    // R6: protection pin in every lane mode
    for (int p = 0; p < 4; p++)
      for (int q = 0; q < 2; q++) begin
        proto = 2'(p); quad_cmd = 1'(q);
        wp_n_pin = 0; step(1);
        wp_n_pin = 1; step(1);
      end

    // R8: boost flag at every window edge and one past the end
    proto = 2'b10; quad_cmd = 0; vpp_dis_cfg = 0;
    for (int k = 1; k <= WIN + 1; k++) begin
      prog_last = 1; step(1);
      prog_last = 0;
      if (k > 1) step(k - 1);
      acc_volt_ok = 1; step(1);
      acc_volt_ok = 0; step(WIN + 2);
    end
    // R8: no flag at all, and a second last-bit inside the window
    prog_last = 1; step(1);
    step(2);
    prog_last = 1; step(1);
    prog_last = 0; step(WIN + 2);

    // R9 R7: boost disabled or narrow mode gives standard at once
    vpp_dis_cfg = 1; prog_last = 1; step(1);
    prog_last = 0; step(2);
    vpp_dis_cfg = 0; proto = 2'b01; prog_last = 1; step(1);
    prog_last = 0; step(2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule